// File: doc/BRIEF.md
# Dual-channel LVDS video deserializer

This block rebuilds a parallel video bus from ten serial data lanes that an analog front end has already sampled. It runs on a bit-rate clock, where each clock edge delivers one bit on every lane. Seven consecutive bits on a lane form one pixel slot. The lanes are split into two channels of five lanes each, so every pixel slot yields a 35-bit word per channel. Each word is unpacked into 30 bits of RGB colour. Channel 0 also carries HSYNC, VSYNC, DE and two user bits. The block produces a pixel-rate output clock, and the parallel outputs update on the rising or the falling edge of that clock, chosen by a strobe-select pin.

A small control register, loaded through a simple write port, sets the remaining options:
- single-pixel mode, in which channel 1 is silenced;
- a per-channel disable that freezes the outputs of that channel;
- a staggered mode that moves one chosen channel to the opposite output-clock edge, so the two channels never switch together.

A power-down input clears every output and restarts the 7-bit slot framing from the next clock.

Top module: `dual_lvds_deser`

## Requirements
- R1: While reset is low, every parallel output and `out_clk` are 0, and the control register is 0 (dual-pixel, both channels on, no stagger).
- R2: Lane `l` of channel `c` is `ser_lane[c*5+l]`. The bit received in slot position `b` (0..6) of a frame becomes word bit `l*7+b`. The RGB output is word bits [34:5], with R in output bits [29:20], G in [19:10] and B in [9:0]. On channel 0, word bits 0..4 drive `hsync`, `vsync`, `de`, `usr[0]` and `usr[1]`, in that order.
- R3: The first clock edge after reset or power-down is released takes slot position 0. After that, frames follow back to back, 7 edges each.
- R4: `out_clk` is 1 after the edges at slot positions 0..3 and 0 after the edges at positions 4..6. It therefore rises with slot 0 and falls with slot 4.
- R5: With `edge_fall`=0, a frame whose last bit arrives at edge 7f+6 appears on the outputs after edge 7f+7, which is the edge on which `out_clk` rises. The outputs do not change earlier.
- R6: With `edge_fall`=1, the same frame appears after edge 7f+11, which is the edge on which `out_clk` falls.
- R7: When stagger is enabled (control bit 3), the channel chosen by control bit 4 shows the same frame on the opposite `out_clk` edge: 4 edges later in rising mode and 3 edges later in falling mode. The other channel keeps its normal timing.
- R8: With stagger off, both channels update on the same clock edge.
- R9: A channel whose off bit is set (bit 1 for channel 0, bit 2 for channel 1) holds its outputs static, and the other channel keeps updating.
- R10: When control bit 0 (single-pixel mode) is set, the channel 1 RGB outputs are 0 from the following edge onward.
- R11: While `pwr_dn` is 1, every parallel output and `out_clk` are 0 after the next clock edge.
- R12: A write with `cfg_we`=1 and `cfg_addr`=0 loads `cfg_wdata` into the control register on the clock edge. A write to any other address leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock (seven edges per pixel) |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| pwr_dn | input | 1 | Power-down: clears outputs and slot framing |
| edge_fall | input | 1 | Output strobe select: 0 = rising edge of out_clk, 1 = falling edge |
| ser_lane | input | 10 | Sampled serial lanes; [4:0] form channel 0, [9:5] form channel 1 |
| cfg_we | input | 1 | Control register write strobe |
| cfg_addr | input | 2 | Control register write address |
| cfg_wdata | input | 5 | Control write data: bit0 single, bit1 ch0 off, bit2 ch1 off, bit3 stagger on, bit4 staggered channel |
| out_clk | output | 1 | Recovered pixel-rate output clock |
| ch0_rgb | output | 30 | Channel 0 colour {R,G,B} |
| ch1_rgb | output | 30 | Channel 1 colour {R,G,B} |
| hsync | output | 1 | Horizontal sync from channel 0 |
| vsync | output | 1 | Vertical sync from channel 0 |
| de | output | 1 | Data enable from channel 0 |
| usr | output | 2 | User-defined control bits from channel 0 |

## Verification
The bench builds the block with its default parameters: five lanes per channel and seven bits per lane, which gives the 35-bit word with a 30-bit colour field. These defaults give a 4-high/3-low output clock, so the rising and falling strobe points are 4 and 3 edges apart. This lets one back-to-back pair of frames separate every timing case at a single sample point: rising, falling, staggered rising and staggered falling. The same pairs of frames expose the lane-to-bit mapping, the hold of a disabled channel across several frames, and re-alignment after power-down.

// File: rtl/dld_pkg.sv
package dld_pkg;

  // Number of parallel channels (fixed by the lane split).
  localparam int NCH    = 2;
  // Control bits carried on the first lane of channel 0.
  localparam int CTL_W  = 5;
  // Width of the control register.
  localparam int CTRL_W = 5;

  // Control register layout, bit 0 first: single_px, ch0_off, ch1_off,
  // skew_en, skew_ch.
  typedef struct packed {
    logic skew_ch;
    logic skew_en;
    logic ch1_off;
    logic ch0_off;
    logic single_px;
  } ctrl_t;

endpackage

// File: rtl/dld_frame_timer.sv
module dld_frame_timer #(
  parameter int BITS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dn,
  input  logic edge_fall,
  output logic cap_o,
  output logic ld_main_o,
  output logic ld_late_o,
  output logic out_clk_o
);

  localparam int CNT_W = $clog2(BITS);
  localparam int HI    = (BITS + 1) / 2;
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(BITS - 1);
  localparam logic [CNT_W-1:0] HI_C   = CNT_W'(HI);
  localparam logic [CNT_W-1:0] ZERO_C = '0;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             oclk_q, oclk_d;

  always_comb begin
    if (pwr_dn) begin
      cnt_d  = '0;
      oclk_d = 1'b0;
    end else begin
      cnt_d  = (cnt_q == LAST_C) ? '0 : cnt_q + 1'b1;
      oclk_d = (cnt_q < HI_C);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      oclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      oclk_q <= oclk_d;
    end
  end

  // The main load point sits on the selected out_clk edge, the late one on
  // the opposite edge.
  assign cap_o     = !pwr_dn && (cnt_q == LAST_C);
  assign ld_main_o = !pwr_dn && (cnt_q == (edge_fall ? HI_C : ZERO_C));
  assign ld_late_o = !pwr_dn && (cnt_q == (edge_fall ? ZERO_C : HI_C));
  assign out_clk_o = oclk_q;

endmodule

// File: rtl/dld_lane_shifter.sv
module dld_lane_shifter #(
  parameter int LANES = 5,
  parameter int BITS  = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pwr_dn,
  input  logic                   cap_i,
  input  logic [LANES-1:0]       lane_i,
  output logic [LANES*BITS-1:0]  word_o
);

  localparam int WORD = LANES * BITS;

  logic [WORD-1:0] frame_w;
  logic [WORD-1:0] word_q, word_d;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BITS-2:0] sh_q, sh_d;

    // The newest bit enters at the top, so the first bit of a slot ends up
    // at position 0.
    always_comb begin
      sh_d = pwr_dn ? '0 : {lane_i[l], sh_q[BITS-2:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end

    assign frame_w[l*BITS +: BITS] = {lane_i[l], sh_q};
  end

  always_comb begin
    if (pwr_dn)     word_d = '0;
    else if (cap_i) word_d = frame_w;
    else            word_d = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word_o = word_q;

endmodule

// File: rtl/dld_chan_out.sv
module dld_chan_out #(
  parameter int W = 35
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_dn,
  input  logic         zero_i,
  input  logic         en_i,
  input  logic         late_i,
  input  logic         ld_main_i,
  input  logic         ld_late_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] data_o
);

  logic [W-1:0] stage_q, stage_d;
  logic [W-1:0] out_q, out_d;

  // The stage keeps the frame taken at the main point, so the late copy
  // always shows the same frame as the other channel.
  always_comb begin
    if (pwr_dn)                 stage_d = '0;
    else if (en_i && ld_main_i) stage_d = word_i;
    else                        stage_d = stage_q;
  end

  always_comb begin
    if (pwr_dn || zero_i)                  out_d = '0;
    else if (en_i && !late_i && ld_main_i) out_d = word_i;
    else if (en_i && late_i && ld_late_i)  out_d = stage_q;
    else                                   out_d = out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      out_q   <= '0;
    end else begin
      stage_q <= stage_d;
      out_q   <= out_d;
    end
  end

  assign data_o = out_q;

endmodule

// File: rtl/dual_lvds_deser.sv
module dual_lvds_deser
  import dld_pkg::*;
#(
  parameter int LANES_PER_CH  = 5,
  parameter int BITS_PER_LANE = 7,
  parameter int ADDR_W        = 2
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        pwr_dn,
  input  logic                                        edge_fall,
  input  logic [NCH*LANES_PER_CH-1:0]                 ser_lane,
  input  logic                                        cfg_we,
  input  logic [ADDR_W-1:0]                           cfg_addr,
  input  logic [CTRL_W-1:0]                           cfg_wdata,
  output logic                                        out_clk,
  output logic [LANES_PER_CH*BITS_PER_LANE-CTL_W-1:0] ch0_rgb,
  output logic [LANES_PER_CH*BITS_PER_LANE-CTL_W-1:0] ch1_rgb,
  output logic                                        hsync,
  output logic                                        vsync,
  output logic                                        de,
  output logic [1:0]                                  usr
);

  localparam int WORD = LANES_PER_CH * BITS_PER_LANE;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

  // Control register.
  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    if (cfg_we && (cfg_addr == CTRL_ADDR)) ctrl_d = ctrl_t'(cfg_wdata);
    else                                   ctrl_d = ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  // Slot framing and strobe points.
  logic cap_w, ld_main_w, ld_late_w;

  dld_frame_timer #(.BITS(BITS_PER_LANE)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_dn    (pwr_dn),
    .edge_fall (edge_fall),
    .cap_o     (cap_w),
    .ld_main_o (ld_main_w),
    .ld_late_o (ld_late_w),
    .out_clk_o (out_clk)
  );

  // Per-channel qualifiers.
  logic [NCH-1:0] en_w, zero_w;

  always_comb begin
    en_w[0]   = !ctrl_q.ch0_off;
    en_w[1]   = !ctrl_q.ch1_off && !ctrl_q.single_px;
    zero_w[0] = 1'b0;
    zero_w[1] = ctrl_q.single_px;
  end

  logic [WORD-1:0] word_w [NCH];
  logic [WORD-1:0] out_w  [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic late_w;
    assign late_w = ctrl_q.skew_en && (ctrl_q.skew_ch == 1'(c));

    dld_lane_shifter #(.LANES(LANES_PER_CH), .BITS(BITS_PER_LANE)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .pwr_dn (pwr_dn),
      .cap_i  (cap_w),
      .lane_i (ser_lane[c*LANES_PER_CH +: LANES_PER_CH]),
      .word_o (word_w[c])
    );

    dld_chan_out #(.W(WORD)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_dn    (pwr_dn),
      .zero_i    (zero_w[c]),
      .en_i      (en_w[c]),
      .late_i    (late_w),
      .ld_main_i (ld_main_w),
      .ld_late_i (ld_late_w),
      .word_i    (word_w[c]),
      .data_o    (out_w[c])
    );
  end

  // Unpack: colour above the control field, control only used on channel 0.
  assign ch0_rgb                   = out_w[0][WORD-1:CTL_W];
  assign ch1_rgb                   = out_w[1][WORD-1:CTL_W];
  assign {usr, de, vsync, hsync}   = out_w[0][CTL_W-1:0];

  logic ch1_ctl_unused;
  assign ch1_ctl_unused = ^out_w[1][CTL_W-1:0];

endmodule

// File: rtl/dld_checker.sv
module dld_checker
  import dld_pkg::*;
#(
  parameter int RGB_W  = 30,
  parameter int ADDR_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_dn,
  input logic             cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input ctrl_t            ctrl,
  input logic             out_clk,
  input logic [RGB_W-1:0] ch0_rgb,
  input logic [RGB_W-1:0] ch1_rgb,
  input logic             hsync,
  input logic             vsync,
  input logic             de,
  input logic [1:0]       usr
);

  assert_pd_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (!out_clk && ch0_rgb == '0 && ch1_rgb == '0 &&
                {usr, de, vsync, hsync} == '0));

  assert_single_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.single_px |=> (ch1_rgb == '0));

  assert_hold_ch0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.ch0_off && !pwr_dn) |=> $stable(ch0_rgb));

  assert_hold_ch1_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.ch1_off && !ctrl.single_px && !pwr_dn) |=> $stable(ch1_rgb));

  assert_cfg_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr != '0) |=> $stable(ctrl));

  // R5 / R6: channel 0 only ever changes together with an out_clk edge.
  assert_change_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ch0_rgb) && !$past(pwr_dn)) |-> !$stable(out_clk));

  assert_outclk_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_clk) && !pwr_dn) |=> out_clk);

endmodule

bind dual_lvds_deser dld_checker #(
  .RGB_W  (LANES_PER_CH*BITS_PER_LANE - dld_pkg::CTL_W),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwr_dn   (pwr_dn),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .ctrl     (ctrl_q),
  .out_clk  (out_clk),
  .ch0_rgb  (ch0_rgb),
  .ch1_rgb  (ch1_rgb),
  .hsync    (hsync),
  .vsync    (vsync),
  .de       (de),
  .usr      (usr)
);

// File: tb/dual_lvds_deser_tb_top.sv
module dual_lvds_deser_tb_top;

  logic        clk;
  logic        rst_n;
  logic        pwr_dn;
  logic        edge_fall;
  logic [9:0]  ser_lane;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [4:0]  cfg_wdata;
  logic        out_clk;
  logic [29:0] ch0_rgb, ch1_rgb;
  logic        hsync, vsync, de;
  logic [1:0]  usr;

  int nchecks = 0;
  int nerr    = 0;

  dual_lvds_deser dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_dn    (pwr_dn),
    .edge_fall (edge_fall),
    .ser_lane  (ser_lane),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .out_clk   (out_clk),
    .ch0_rgb   (ch0_rgb),
    .ch1_rgb   (ch1_rgb),
    .hsync     (hsync),
    .vsync     (vsync),
    .de        (de),
    .usr       (usr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Test frames, one 35-bit word per channel.
  localparam logic [34:0] P0 = 35'h5A5C31E2D, P1 = 35'h31234ABCD;
  localparam logic [34:0] Q0 = 35'h60F0F33C7, Q1 = 35'h2ABCD0F15;
  localparam logic [34:0] R0 = 35'h111112222, R1 = 35'h444448888;
  localparam logic [34:0] S0 = 35'h70000FFFF, S1 = 35'h05555AAAA;

  function automatic logic [29:0] rgb_of(input logic [34:0] w);
    return w[34:5];
  endfunction

  function automatic logic [4:0] ctl_of(input logic [34:0] w);
    return w[4:0];
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // All tasks enter and leave on a falling clock edge.
  task automatic push_frame(input logic [34:0] w0, input logic [34:0] w1);
    for (int b = 0; b < 7; b++) begin
      for (int l = 0; l < 5; l++) begin
        ser_lane[l]     = w0[l*7 + b];
        ser_lane[5 + l] = w1[l*7 + b];
      end
      @(negedge clk);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [4:0] d);
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic start_run(input logic [4:0] cfg, input logic fall);
    pwr_dn    = 1'b1;
    edge_fall = fall;
    cfg_write(2'd0, cfg);
    pwr_dn    = 1'b0;
  endtask

  task automatic test_reset;
    chk("R1", "out_clk in reset", 64'(out_clk), 64'd0);
    chk("R1", "ch0_rgb in reset", 64'(ch0_rgb), 64'd0);
    chk("R1", "ch1_rgb in reset", 64'(ch1_rgb), 64'd0);
    chk("R1", "ctl in reset", 64'({usr, de, vsync, hsync}), 64'd0);
  endtask

  task automatic test_rise_map;
    start_run(5'b00000, 1'b0);
    push_frame(P0, P1);
    chk("R5", "ch0 before strobe", 64'(ch0_rgb), 64'd0);
    push_frame(Q0, Q1);
    chk("R2", "ch0_rgb map", 64'(ch0_rgb), 64'(rgb_of(P0)));
    chk("R2", "ch1_rgb map", 64'(ch1_rgb), 64'(rgb_of(P1)));
    chk("R2", "ctl map", 64'({usr, de, vsync, hsync}), 64'(ctl_of(P0)));
    @(negedge clk);
    chk("R5", "ch0 next frame", 64'(ch0_rgb), 64'(rgb_of(Q0)));
    chk("R8", "ch1 same edge", 64'(ch1_rgb), 64'(rgb_of(Q1)));
  endtask

  task automatic test_outclk;
    start_run(5'b00000, 1'b0);
    for (int m = 1; m <= 14; m++) begin
      @(negedge clk);
      chk("R4", $sformatf("out_clk slot %0d", (m - 1) % 7),
          64'(out_clk), 64'(((m - 1) % 7) < 4));
    end
  endtask

  task automatic test_fall;
    start_run(5'b00000, 1'b1);
    push_frame(P0, P1);
    push_frame(Q0, Q1);
    chk("R6", "ch0 after fall", 64'(ch0_rgb), 64'(rgb_of(P0)));
    @(negedge clk);
    chk("R6", "ch0 holds on rise", 64'(ch0_rgb), 64'(rgb_of(P0)));
    repeat (3) @(negedge clk);
    chk("R6", "ch0 before next fall", 64'(ch0_rgb), 64'(rgb_of(P0)));
    @(negedge clk);
    chk("R6", "ch0 at next fall", 64'(ch0_rgb), 64'(rgb_of(Q0)));
  endtask

  task automatic test_skew_rise;
    start_run(5'b11000, 1'b0);
    push_frame(P0, P1);
    push_frame(Q0, Q1);
    chk("R7", "late ch1 frame P", 64'(ch1_rgb), 64'(rgb_of(P1)));
    @(negedge clk);
    chk("R7", "ch0 normal timing", 64'(ch0_rgb), 64'(rgb_of(Q0)));
    chk("R7", "ch1 still lags", 64'(ch1_rgb), 64'(rgb_of(P1)));
    repeat (3) @(negedge clk);
    chk("R7", "ch1 before falling edge", 64'(ch1_rgb), 64'(rgb_of(P1)));
    @(negedge clk);
    chk("R7", "ch1 at falling edge", 64'(ch1_rgb), 64'(rgb_of(Q1)));
  endtask

  task automatic test_skew_fall;
    start_run(5'b01000, 1'b1);
    push_frame(P0, P1);
    push_frame(Q0, Q1);
    chk("R7", "ch1 normal on fall", 64'(ch1_rgb), 64'(rgb_of(P1)));
    chk("R7", "late ch0 not yet", 64'(ch0_rgb), 64'd0);
    @(negedge clk);
    chk("R7", "late ch0 on rise", 64'(ch0_rgb), 64'(rgb_of(P0)));
  endtask

  task automatic test_disable;
    start_run(5'b00000, 1'b0);
    push_frame(P0, P1);
    push_frame(Q0, Q1);
    fork
      push_frame(R0, R1);
      cfg_write(2'd0, 5'b00100);
    join
    push_frame(S0, S1);
    chk("R9", "ch0 keeps running", 64'(ch0_rgb), 64'(rgb_of(R0)));
    chk("R9", "ch1 held", 64'(ch1_rgb), 64'(rgb_of(Q1)));
  endtask

  task automatic test_single;
    start_run(5'b00001, 1'b0);
    push_frame(P0, P1);
    push_frame(Q0, Q1);
    chk("R10", "ch0 in single mode", 64'(ch0_rgb), 64'(rgb_of(P0)));
    chk("R10", "ch1 low in single mode", 64'(ch1_rgb), 64'd0);
  endtask

  task automatic test_pd;
    start_run(5'b00000, 1'b0);
    push_frame(P0, P1);
    push_frame(Q0, Q1);
    @(negedge clk);
    pwr_dn = 1'b1;
    @(negedge clk);
    chk("R11", "ch0 in power-down", 64'(ch0_rgb), 64'd0);
    chk("R11", "ch1 in power-down", 64'(ch1_rgb), 64'd0);
    chk("R11", "out_clk in power-down", 64'(out_clk), 64'd0);
    chk("R11", "ctl in power-down", 64'({usr, de, vsync, hsync}), 64'd0);
    pwr_dn = 1'b0;
    push_frame(R0, R1);
    push_frame(S0, S1);
    chk("R3", "ch0 realigned", 64'(ch0_rgb), 64'(rgb_of(R0)));
    chk("R3", "ch1 realigned", 64'(ch1_rgb), 64'(rgb_of(R1)));
  endtask

  task automatic test_bad_addr;
    pwr_dn    = 1'b1;
    edge_fall = 1'b0;
    cfg_write(2'd0, 5'b00000);
    cfg_write(2'd2, 5'b00111);
    cfg_write(2'd3, 5'b11111);
    pwr_dn    = 1'b0;
    push_frame(P0, P1);
    push_frame(Q0, Q1);
    chk("R12", "ch0 unaffected", 64'(ch0_rgb), 64'(rgb_of(P0)));
    chk("R12", "ch1 unaffected", 64'(ch1_rgb), 64'(rgb_of(P1)));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    pwr_dn    = 1'b1;
    edge_fall = 1'b0;
    ser_lane  = '0;
    cfg_we    = 1'b0;
    cfg_addr  = '0;
    cfg_wdata = '0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_rise_map();
    test_outclk();
    test_fall();
    test_skew_rise();
    test_skew_fall();
    test_disable();
    test_single();
    test_pd();
    test_bad_addr();
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

endmodule